// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block is the digital heart of a high-speed CAN line driver. It decides whether the transceiver is unpowered, in low-power standby, in receive-only silent mode or in full normal operation. It works from the standby control pin, the transmit-data pin, two supply-undervoltage flags, the bus comparator output, the level actually present on the receive-data pin and an overtemperature flag. From these it produces the current mode, an enable for the bus driver, an enable for the high-speed bus comparator and a select that chooses what drives the receive-data pin: live bus data or the wake flag from the separate wake filter.

All pin-level inputs pass through a parameterised synchronizer before use. Two protection rules sit inside the controller. The first is a recessive-clamp detector: while the bus comparator reports dominant and the receive pin stays recessive, a counter runs, and when the count exceeds its limit the controller drops to receive-only mode. The second is an overtemperature latch that keeps the driver off until the flag has cleared and transmit-data has gone high again. The analog comparators, the slope control and the wake filter live elsewhere.

Top module: `cantx_mode_ctrl`

## Requirements
- R1: During and right after reset the mode is unpowered, with drive_en = 0, cmp_en = 0 and rx_from_wake = 1. Mode encoding: 2'b00 unpowered, 2'b01 standby, 2'b10 silent, 2'b11 normal.
- R2: While either vcc_low or vio_low is high, the mode becomes and stays unpowered, whatever the standby pin says. When both flags are low again, the controller moves to standby.
- R3: In standby mode, drive_en = 0, cmp_en = 0 and rx_from_wake = 1. The controller enters standby from any powered mode when stby_n_pin is high.
- R4: Normal mode is entered from standby only when stby_n_pin is low and txd_pin is high. While txd_pin is low, the controller stays in standby.
- R5: Once stby_n_pin is low, txd_pin is high and both supplies are good, the controller reaches normal mode within SYNC_STAGES+1 clocks, never later than MAX_ENTRY_CYCLES.
- R6: In normal mode without overtemperature, drive_en = 1, cmp_en = 1 and rx_from_wake = 0. A low txd_pin does not take the controller out of normal mode.
- R7: In normal mode, if bus_dom stays 1 with rxd_level at 1 for more than CLAMP_CYCLES consecutive synchronized cycles, the controller enters silent mode, with drive_en = 0, cmp_en = 1 and rx_from_wake = 0. A shorter run, or a run broken by rxd_level = 0 or bus_dom = 0, leaves the mode at normal.
- R8: Silent mode goes back to normal when rxd_level is 0. It goes to standby when stby_n_pin is high, and to unpowered on an undervoltage.
- R9: While over_temp is high, drive_en is 0. After over_temp clears, drive_en stays 0 while txd_pin is low, and returns to 1 once txd_pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_n_pin | input | 1 | Standby control pin; high requests standby |
| txd_pin | input | 1 | Transmit-data pin; low is dominant |
| vcc_low | input | 1 | Main supply undervoltage flag |
| vio_low | input | 1 | I/O supply undervoltage flag |
| bus_dom | input | 1 | High-speed comparator output; 1 means dominant bus |
| rxd_level | input | 1 | Level seen on the receive-data pin; 0 means dominant |
| over_temp | input | 1 | Overtemperature flag |
| mode | output | 2 | Current mode (00 unpowered, 01 standby, 10 silent, 11 normal) |
| drive_en | output | 1 | Bus driver enable |
| cmp_en | output | 1 | High-speed comparator enable |
| rx_from_wake | output | 1 | 1: receive pin shows the wake flag; 0: bus data |

## Verification
On every cycle, the assertions check several things: the driver is never enabled outside normal mode or during overtemperature, standby keeps the comparator off and routes the wake flag, and an undervoltage always forces the unpowered mode. They also check that normal mode is only ever entered with transmit-data high, that silent mode is only entered while a clamp condition is present, and that the entry latency stays under its bound. Some behaviours only the bench scenarios can show: the exact length of the clamp window, a clamp run that is broken and restarts, the release of the overtemperature latch, which waits for transmit-data, and the three ways out of silent mode. A seeded random sweep over the standby, transmit-data and supply inputs then compares the mode against a model of the transition rules.

// File: rtl/cantx_mode_ctrl.sv
module cantx_mode_ctrl #(
  parameter int SYNC_STAGES      = 2,
  parameter int CLAMP_CYCLES     = 16,
  parameter int MAX_ENTRY_CYCLES = 2350
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_n_pin,
  input  logic       txd_pin,
  input  logic       vcc_low,
  input  logic       vio_low,
  input  logic       bus_dom,
  input  logic       rxd_level,
  input  logic       over_temp,
  output logic [1:0] mode,
  output logic       drive_en,
  output logic       cmp_en,
  output logic       rx_from_wake
);

  localparam int CW = $clog2(CLAMP_CYCLES + 1);
  localparam int EW = $clog2(MAX_ENTRY_CYCLES + 1);
  localparam logic [CW-1:0] CLAMP_MAX = CW'(CLAMP_CYCLES);
  localparam logic [EW-1:0] ENTRY_MAX = EW'(MAX_ENTRY_CYCLES);
  localparam logic [1:0] M_OFF  = 2'b00;
  localparam logic [1:0] M_STBY = 2'b01;
  localparam logic [1:0] M_SIL  = 2'b10;
  localparam logic [1:0] M_NORM = 2'b11;
  localparam logic [6:0] SYNC_RST = 7'b0101111;

  logic [6:0] sync_q [SYNC_STAGES];
  logic s_ot, s_rxd, s_dom, s_vio, s_vcc, s_txd, s_stby;
  logic [1:0] nxt;
  logic [CW-1:0] clamp_cnt;
  logic clamp_cond, ot_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_RST;
    end else begin
      sync_q[0] <= {over_temp, rxd_level, bus_dom, vio_low, vcc_low, txd_pin, stby_n_pin};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {s_ot, s_rxd, s_dom, s_vio, s_vcc, s_txd, s_stby} = sync_q[SYNC_STAGES-1];
  assign clamp_cond = (mode == M_NORM) && s_dom && s_rxd;

  always_comb begin
    nxt = mode;
    if (s_vcc || s_vio) nxt = M_OFF;
    else begin
      case (mode)
        M_OFF:   nxt = M_STBY;
        M_STBY:  if (!s_stby && s_txd) nxt = M_NORM;
        M_NORM:  if (s_stby) nxt = M_STBY;
                 else if (clamp_cond && clamp_cnt == CLAMP_MAX) nxt = M_SIL;
        default: if (s_stby) nxt = M_STBY;
                 else if (!s_rxd) nxt = M_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_OFF;
      clamp_cnt <= '0;
      ot_lock   <= 1'b0;
    end else begin
      mode <= nxt;
      if (!clamp_cond) clamp_cnt <= '0;
      else if (clamp_cnt != CLAMP_MAX) clamp_cnt <= clamp_cnt + 1'b1;
      if (s_ot) ot_lock <= 1'b1;
      else if (s_txd) ot_lock <= 1'b0;
    end
  end

  assign drive_en     = (mode == M_NORM) && !ot_lock && !s_ot;
  assign cmp_en       = mode[1];
  assign rx_from_wake = !mode[1];

  logic [EW-1:0] entry_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entry_cnt <= '0;
    else if (mode == M_STBY && !stby_n_pin && txd_pin && !vcc_low && !vio_low) begin
      if (entry_cnt != ENTRY_MAX) entry_cnt <= entry_cnt + 1'b1;
    end else entry_cnt <= '0;
  end

  // R6
  drive_only_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> mode == M_NORM);
  // R9
  ot_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ot |-> !drive_en);
  // R2
  uv_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vcc || s_vio) |=> mode == M_OFF);
  // R3
  standby_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_STBY |-> (!cmp_en && rx_from_wake && !drive_en));
  // R4
  entry_needs_txd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_STBY && mode == M_NORM) |-> $past(s_txd && !s_stby));
  // R5
  entry_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_cnt < ENTRY_MAX);
  // R7
  silent_needs_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_NORM && mode == M_SIL) |-> $past(s_dom && s_rxd));

endmodule

// File: tb/cantx_mode_ctrl_test.sv
module cantx_mode_ctrl_test;
  localparam int SYNC  = 2;
  localparam int CLAMP = 16;
  localparam int SET   = SYNC + 4;

  logic clk = 0, rst_n = 0;
  logic stby = 1, txd = 1, uvc = 1, uvi = 1, dom = 0, rxd = 1, ot = 0;
  logic [1:0] mode;
  logic drv, cmp, rsel;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cantx_mode_ctrl #(.SYNC_STAGES(SYNC), .CLAMP_CYCLES(CLAMP), .MAX_ENTRY_CYCLES(2350)) uut (
    .clk(clk), .rst_n(rst_n), .stby_n_pin(stby), .txd_pin(txd), .vcc_low(uvc), .vio_low(uvi),
    .bus_dom(dom), .rxd_level(rxd), .over_temp(ot), .mode(mode), .drive_en(drv),
    .cmp_en(cmp), .rx_from_wake(rsel));

  function automatic logic [4:0] vec_of(logic [1:0] m, logic hot);
    case (m)
      2'b00: return 5'b00_0_0_1;
      2'b01: return 5'b01_0_0_1;
      2'b10: return 5'b10_0_1_0;
      default: return {2'b11, !hot, 2'b10};
    endcase
  endfunction

  function automatic logic [1:0] model(logic [1:0] prev, logic s, logic t, logic uv);
    if (uv) return 2'b00;
    if (s) return 2'b01;
    if (t) return 2'b11;
    return (prev == 2'b11) ? 2'b11 : 2'b01;
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act = {mode, drv, cmp, rsel};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {mode,drive,cmp,rxsel} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clamp_run(int n);
    dom = 1; rxd = 1;
    wait_n(n);
    dom = 0;
    wait_n(SET);
  endtask

  initial begin
    wait_n(3);
    chk("R1 reset", vec_of(2'b00, 0));
    rst_n = 1;
    wait_n(1);
    chk("R1 after release", vec_of(2'b00, 0));
    stby = 0; txd = 1;
    wait_n(SET);
    chk("R2 stby ignored under undervoltage", vec_of(2'b00, 0));
    stby = 1; uvc = 0; uvi = 0;
    wait_n(SET);
    chk("R2 recovery to standby / R3", vec_of(2'b01, 0));
    stby = 0; txd = 0;
    wait_n(SET);
    chk("R4 txd low blocks normal", vec_of(2'b01, 0));
    txd = 1;
    wait_n(SYNC);
    chk("R5 not yet normal", vec_of(2'b01, 0));
    wait_n(1);
    chk("R5 normal at SYNC+1", vec_of(2'b11, 0));
    txd = 0;
    wait_n(SET);
    chk("R6 txd low stays normal", vec_of(2'b11, 0));
    txd = 1;
    clamp_run(CLAMP);
    chk("R7 short clamp ignored", vec_of(2'b11, 0));
    dom = 1; rxd = 1; wait_n(CLAMP - 2);
    rxd = 0; wait_n(1);
    rxd = 1; wait_n(CLAMP - 2);
    dom = 0; wait_n(SET);
    chk("R7 broken clamp ignored", vec_of(2'b11, 0));
    clamp_run(CLAMP + 2);
    chk("R7 clamp gives silent", vec_of(2'b10, 0));
    rxd = 0; wait_n(SET); rxd = 1; wait_n(2);
    chk("R8 rxd dominant back to normal", vec_of(2'b11, 0));
    clamp_run(CLAMP + 2);
    chk("R7 clamp again", vec_of(2'b10, 0));
    stby = 1; wait_n(SET);
    chk("R8 silent to standby", vec_of(2'b01, 0));
    stby = 0; wait_n(SET);
    clamp_run(CLAMP + 2);
    uvi = 1; wait_n(SET);
    chk("R8 silent to unpowered", vec_of(2'b00, 0));
    uvi = 0; wait_n(SET);
    chk("R2 recover to normal", vec_of(2'b11, 0));
    ot = 1; wait_n(SET);
    chk("R9 overtemp drive off", vec_of(2'b11, 1));
    txd = 0; wait_n(1); ot = 0; wait_n(SET);
    chk("R9 held off while txd low", vec_of(2'b11, 1));
    txd = 1; wait_n(SET);
    chk("R9 released with txd high", vec_of(2'b11, 0));

    begin
      logic [1:0] pm = 2'b11;
      int unsigned seed = 32'h5eed_1234;
      void'($urandom(seed));
      for (int k = 0; k < 60; k++) begin
        logic [3:0] r = 4'($urandom());
        logic uvr = (r[3:2] == 2'b00);
        stby = r[0]; txd = r[1]; uvc = uvr & r[2]; uvi = uvr & !r[2];
        wait_n(SET);
        pm = model(pm, stby, txd, uvr);
        chk("R2/R3/R4 random sweep", vec_of(pm, 0));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule